// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves transmit data from memory to a byte stream. Software builds a ring of 8-byte buffer descriptors in memory and programs the ring base. It sets the enable bit and then writes the activate register. The engine then fetches descriptors one after another. For each descriptor it reads the referenced buffer byte by byte and presents the bytes on a valid/ready stream. It then writes the descriptor back with its ready bit cleared and moves on. A frame may span several descriptors, and the final byte of a frame carries a last marker.

The walk ends at the first descriptor that is not ready. The pointer stays on that descriptor, so the next activate resumes from it. Single-cycle event pulses report each consumed descriptor, each completed frame, and frames that overran the size cap. All memory traffic uses one 32-bit master port with a request/acknowledge handshake. Buffer bytes are packed big-endian within words.

Top module: `txring_engine`

## Requirements
- R1: After reset, mem_req, tx_valid, evt_buf, evt_frame and evt_babble are all low.
- R2: A register write with reg_sel=2 is an activate. An activate starts a walk only if bit 1 of the control register (reg_sel=0) is set. Otherwise it causes no memory access and no output.
- R3: The descriptor at address D has flags in bits 31:16 and length in bits 15:0 of the word at D, and the buffer address in the word at D+4. Flag bit 15 means ready, bit 13 means wrap and bit 11 means last-in-frame. The buffer byte at address A sits in the word at A with bits 1:0 cleared, in bits 31-8*(A mod 4) down to 24-8*(A mod 4).
- R4: A walk stops when a fetched descriptor has bit 15 clear. The pointer stays on that descriptor.
- R5: After a descriptor is consumed, the next descriptor address is the ring base if its wrap bit is set. Otherwise it is the current address plus 8.
- R6: A consumed descriptor's first word is written back with bit 15 cleared and all other bits unchanged.
- R7: Buffer bytes leave in address order, gathered across descriptors. tx_last is high only on the final byte copied from a last-in-frame descriptor.
- R8: evt_buf pulses once for every consumed descriptor. evt_frame pulses in the same cycle when that descriptor is last-in-frame.
- R9: The bytes of one frame are capped at 2032. A descriptor whose copy is cut short by the cap pulses evt_babble together with its evt_buf.
- R10: The frame byte count restarts from zero after every last-in-frame descriptor.
- R11: A write with reg_sel=1 sets the ring base to the written value with bits 1:0 forced to zero. When the engine is idle, it also loads the descriptor pointer from that value.
- R12: An activate that arrives during a walk is remembered. It starts a new walk once the current one has stopped.
- R13: A memory request holds its address, direction and data until it is acknowledged. A stream byte holds its data and tx_last until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 ring base, 2 activate |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address (byte address, bits 1:0 zero) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| evt_buf | output | 1 | Descriptor consumed pulse |
| evt_frame | output | 1 | Frame completed pulse |
| evt_babble | output | 1 | Frame overran the size cap pulse |

## Verification
A wrong descriptor pointer shows at the ports as early as the next descriptor fetch: mem_addr carries an address other than the base or the old address plus 8. This shows up as fetches at a wrapped or unaligned location, or as a stop descriptor that is read only once when a held activate should have re-read it. A wrong frame byte count shows one frame later, as a missing or misplaced tx_last, or as a following frame delivered short. Stale descriptor flags show at the writeback in the same descriptor, and in the evt_frame pulse that follows one cycle later.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_KICK = 2'd2;

    typedef enum logic [2:0] {
        W_IDLE,
        W_DESC0,
        W_DESC1,
        W_FETCH,
        W_SEND,
        W_WBACK
    } wstate_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic          kick,
    output logic          base_ld,
    output logic [AW-1:0] base_val,
    output logic [AW-1:0] base_q
);
    import txr_pkg::*;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
    } regs_t;

    regs_t r_d, r_q;

    assign base_val = {reg_wdata[AW-1:2], 2'b00};
    assign base_ld  = reg_wr && (reg_sel == SEL_BASE);
    assign kick     = reg_wr && (reg_sel == SEL_KICK) && r_q.en;
    assign base_q   = r_q.base;

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_sel == SEL_CTRL) r_d.en = reg_wdata[1];
        if (base_ld) r_d.base = base_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R11: ring base register never holds a misaligned value
    assert_base_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.base[1:0] == 2'b00);
endmodule

// File: rtl/txr_walker.sv
module txr_walker #(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2032,
    localparam int CW       = $clog2(MAX_FRAME + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kick,
    input  logic          base_ld,
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] base_q,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          evt_buf,
    output logic          evt_frame,
    output logic          evt_babble
);
    import txr_pkg::*;

    typedef struct packed {
        wstate_e       st;
        logic [AW-1:0] cur;
        logic          pend;
        logic [15:0]   flags;
        logic [15:0]   len;
        logic [AW-1:0] baddr;
        logic [CW-1:0] left;
        logic [CW-1:0] fcnt;
        logic          trunc;
        logic [7:0]    dbyte;
        logic          ev_buf;
        logic          ev_frame;
        logic          ev_babble;
    } walk_t;

    walk_t w_d, w_q;
    logic [CW-1:0] room;

    assign room = CW'(MAX_FRAME) - w_q.fcnt;

    always_comb begin
        w_d           = w_q;
        w_d.ev_buf    = 1'b0;
        w_d.ev_frame  = 1'b0;
        w_d.ev_babble = 1'b0;
        if (kick) w_d.pend = 1'b1;
        case (w_q.st)
            W_IDLE: begin
                if (base_ld) begin
                    w_d.cur = base_val;
                end else if (w_q.pend || kick) begin
                    w_d.pend = 1'b0;
                    w_d.st   = W_DESC0;
                end
            end
            W_DESC0: if (mem_ack) begin
                w_d.flags = mem_rdata[31:16];
                w_d.len   = mem_rdata[15:0];
                w_d.st    = mem_rdata[16 + FLG_READY] ? W_DESC1 : W_IDLE;
            end
            W_DESC1: if (mem_ack) begin
                w_d.baddr = mem_rdata[AW-1:0];
                if (32'(w_q.len) > 32'(room)) begin
                    w_d.left  = room;
                    w_d.trunc = 1'b1;
                end else begin
                    w_d.left  = CW'(w_q.len);
                    w_d.trunc = 1'b0;
                end
                w_d.st = (w_d.left == '0) ? W_WBACK : W_FETCH;
            end
            W_FETCH: if (mem_ack) begin
                w_d.dbyte = 8'(mem_rdata >> {~w_q.baddr[1:0], 3'b000});
                w_d.st    = W_SEND;
            end
            W_SEND: if (tx_ready) begin
                w_d.baddr = w_q.baddr + AW'(1);
                w_d.left  = w_q.left - CW'(1);
                w_d.fcnt  = w_q.fcnt + CW'(1);
                w_d.st    = (w_q.left == CW'(1)) ? W_WBACK : W_FETCH;
            end
            W_WBACK: if (mem_ack) begin
                w_d.ev_buf    = 1'b1;
                w_d.ev_frame  = w_q.flags[FLG_LAST];
                w_d.ev_babble = w_q.trunc;
                if (w_q.flags[FLG_LAST]) w_d.fcnt = '0;
                w_d.cur = w_q.flags[FLG_WRAP] ? base_q : w_q.cur + AW'(8);
                w_d.st  = W_DESC0;
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = w_q.cur;
        mem_wdata = {w_q.flags & ~(16'd1 << FLG_READY), w_q.len};
        case (w_q.st)
            W_DESC0: mem_req = 1'b1;
            W_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = w_q.cur + AW'(4);
            end
            W_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {w_q.baddr[AW-1:2], 2'b00};
            end
            W_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign tx_valid   = (w_q.st == W_SEND);
    assign tx_data    = w_q.dbyte;
    assign tx_last    = tx_valid && (w_q.left == CW'(1)) && w_q.flags[FLG_LAST];
    assign evt_buf    = w_q.ev_buf;
    assign evt_frame  = w_q.ev_frame;
    assign evt_babble = w_q.ev_babble;

    // R13: a pending memory request holds until acknowledged
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    // R13: an offered stream byte holds until accepted
    assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
    // R9: frame byte count never passes the cap
    assert_frame_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(w_q.fcnt) <= MAX_FRAME);
    // R8: a frame event always accompanies a buffer event
    assert_frame_with_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_frame |-> evt_buf);
    // R7: stream output and memory traffic never overlap
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && tx_valid));
    // R5: descriptor pointer stays word aligned
    assert_ptr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.cur[1:0] == 2'b00);
endmodule

// File: rtl/txring_engine.sv
module txring_engine #(
    parameter int AW        = 32,
    parameter int MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    output logic          evt_buf,
    output logic          evt_frame,
    output logic          evt_babble
);
    logic          kick;
    logic          base_ld;
    logic [AW-1:0] base_val;
    logic [AW-1:0] base_q;

    txr_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .kick      (kick),
        .base_ld   (base_ld),
        .base_val  (base_val),
        .base_q    (base_q)
    );

    txr_walker #(.AW(AW), .MAX_FRAME(MAX_FRAME)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick       (kick),
        .base_ld    (base_ld),
        .base_val   (base_val),
        .base_q     (base_q),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .evt_buf    (evt_buf),
        .evt_frame  (evt_frame),
        .evt_babble (evt_babble)
    );
endmodule

// File: tb/txring_engine_tb.sv
module txring_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_last, tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        evt_buf, evt_frame, evt_babble;
    logic        stall_en = 1'b0;
    logic [31:0] cyc = '0;

    logic [31:0] mem [0:1023];
    logic [7:0]  rx_byte [0:4095];
    logic        rx_last [0:4095];
    int nrx, n_buf, n_frame, n_babble, w0_cnt, w1_cnt, nlast;
    logic [31:0] w0_addr = 32'hFFFF_FFFF, w1_addr = 32'hFFFF_FFFF;
    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    txring_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .evt_buf(evt_buf), .evt_frame(evt_frame),
        .evt_babble(evt_babble)
    );

    assign mem_ack   = mem_req && !(stall_en && cyc[1]);
    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            if (mem_req && mem_ack && !mem_we && mem_addr == w0_addr) w0_cnt++;
            if (mem_req && mem_ack && !mem_we && mem_addr == w1_addr) w1_cnt++;
            if (tx_valid && tx_ready) begin
                rx_byte[nrx] = tx_data;
                rx_last[nrx] = tx_last;
                if (tx_last) nlast++;
                nrx++;
            end
            if (evt_buf) n_buf++;
            if (evt_frame) n_frame++;
            if (evt_babble) n_babble++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        nrx = 0; n_buf = 0; n_frame = 0; n_babble = 0; w0_cnt = 0; w1_cnt = 0; nlast = 0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed + i * 7) & 255);
    endfunction

    task automatic set_byte(input int a, input logic [7:0] v);
        int lane = a & 3;
        mem[a >> 2][(31 - 8 * lane) -: 8] = v;
    endtask

    task automatic fill(input int a, input int n, input int seed);
        for (int i = 0; i < n; i++) set_byte(a + i, pat(seed, i));
    endtask

    task automatic set_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input int b);
        mem[a >> 2]       = {fl, ln};
        mem[(a >> 2) + 1] = b;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 6 && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (!mem_req && !tx_valid) quiet++; else quiet = 0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 mem_req", int'(mem_req), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 events", int'(evt_buf | evt_frame | evt_babble), 0);
    endtask

    task automatic t_disabled();
        clear_counts();
        set_desc(32'h100, 16'h8800, 16'd2, 32'h300);
        fill(32'h300, 2, 11);
        reg_write(2'd1, 32'h100);
        w0_addr = 32'h100;
        reg_write(2'd2, 0);
        repeat (30) @(negedge clk);
        chk("R2 no bytes when disabled", nrx, 0);
        chk("R2 no fetch when disabled", w0_cnt, 0);
    endtask

    task automatic t_single();
        clear_counts();
        reg_write(2'd0, 32'h2);
        w0_addr = 32'h108;
        reg_write(2'd2, 0);
        wait_idle();
        chk("R7 single frame bytes", nrx, 2);
        chk("R3 byte0", int'(rx_byte[0]), int'(pat(11, 0)));
        chk("R3 byte1", int'(rx_byte[1]), int'(pat(11, 1)));
        chk("R7 last on final", int'(rx_last[1]), 1);
        chk("R7 not last on first", int'(rx_last[0]), 0);
        chk("R8 buf events", n_buf, 1);
        chk("R8 frame events", n_frame, 1);
        chk("R6 writeback", int'(mem[32'h100 >> 2]), int'({16'h0800, 16'd2}));
        chk("R4 stop descriptor fetched once", w0_cnt, 1);
    endtask

    task automatic t_gather();
        clear_counts();
        stall_en = 1'b1;
        set_desc(32'h108, 16'h8000, 16'd3, 32'h340);
        set_desc(32'h110, 16'h8800, 16'd2, 32'h343);
        set_desc(32'h118, 16'h0000, 16'd0, 0);
        fill(32'h340, 5, 40);
        w0_addr = 32'h118;
        reg_write(2'd2, 0);
        wait_idle();
        stall_en = 1'b0;
        chk("R7 gathered bytes", nrx, 5);
        for (int i = 0; i < 5; i++) begin
            chk("R7 gathered data", int'(rx_byte[i]), int'(pat(40, i)));
            chk("R7 gathered last", int'(rx_last[i]), (i == 4) ? 1 : 0);
        end
        chk("R8 buf per descriptor", n_buf, 2);
        chk("R8 one frame", n_frame, 1);
        chk("R5 advance by 8 reaches stop", w0_cnt, 1);
        chk("R6 first desc cleared", int'(mem[32'h108 >> 2]), int'({16'h0000, 16'd3}));
    endtask

    task automatic t_wrap();
        clear_counts();
        set_desc(32'h200, 16'hA800, 16'd1, 32'h350);
        fill(32'h350, 1, 90);
        w0_addr = 32'h200;
        w1_addr = 32'h208;
        reg_write(2'd1, 32'h203);
        reg_write(2'd2, 0);
        wait_idle();
        chk("R11 masked base byte", nrx, 1);
        chk("R11 data", int'(rx_byte[0]), int'(pat(90, 0)));
        chk("R5 wrap returns to base", w0_cnt, 2);
        chk("R5 no advance past wrap", w1_cnt, 0);
        chk("R6 wrap flag kept", int'(mem[32'h200 >> 2]), int'({16'h2800, 16'd1}));
        w1_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_pending();
        clear_counts();
        set_desc(32'h000, 16'h8800, 16'd4, 32'h360);
        set_desc(32'h008, 16'h0000, 16'd0, 0);
        fill(32'h360, 4, 5);
        reg_write(2'd1, 32'h000);
        w0_addr = 32'h008;
        tx_ready = 1'b0;
        reg_write(2'd2, 0);
        repeat (10) @(negedge clk);
        reg_write(2'd2, 0);
        repeat (5) @(negedge clk);
        tx_ready = 1'b1;
        wait_idle();
        chk("R12 bytes once", nrx, 4);
        chk("R12 held activate refetches stop", w0_cnt, 2);
        chk("R13 data after stall", int'(rx_byte[0]), int'(pat(5, 0)));
    endtask

    task automatic t_trunc();
        clear_counts();
        set_desc(32'h040, 16'h8000, 16'd2000, 32'h400);
        set_desc(32'h048, 16'h8800, 16'd100, 32'hC00);
        set_desc(32'h050, 16'h8800, 16'd3, 32'h370);
        set_desc(32'h058, 16'h0000, 16'd0, 0);
        fill(32'h400, 2000, 1);
        fill(32'hC00, 100, 77);
        fill(32'h370, 3, 200);
        reg_write(2'd1, 32'h040);
        reg_write(2'd2, 0);
        wait_idle();
        chk("R9 capped plus next frame", nrx, 2035);
        chk("R9 last at cap", int'(rx_last[2031]), 1);
        chk("R9 byte at cap", int'(rx_byte[2031]), int'(pat(77, 31)));
        chk("R9 babble event", n_babble, 1);
        chk("R6 length kept", int'(mem[32'h048 >> 2]), int'({16'h0800, 16'd100}));
        chk("R10 next frame first byte", int'(rx_byte[2032]), int'(pat(200, 0)));
        chk("R10 next frame last", int'(rx_last[2034]), 1);
        chk("R10 frames", nlast, 2);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clear_counts();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_single();
        t_gather();
        t_wrap();
        t_pending();
        t_trunc();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule